// File: doc/BRIEF.md
# Byte FIFO with Selectable Read Latency

A single-clock synchronous first-in first-out buffer for bytes. A producer pushes a byte with a write request and a consumer pulls one with a read request. The buffer reports an empty flag, a full flag and a used-word count. A requested write while full and a requested read while empty are both dropped, so the pointers can never overrun each other.

A build-time parameter picks how the read port behaves. In registered mode the popped byte appears on the output on the clock edge that accepts the read request, so it becomes visible one cycle after the consumer raised the request. The output starts at zero. A consumer that latches the output in the request cycle therefore receives 0x00 first and then stays one word behind. In show-ahead mode the oldest stored byte is already on the output while the buffer holds data, and a read request discards it and moves on to the next one. The flags and the count behave the same in both modes.

Top module: `byte_fifo`

## Requirements
- R1: A synchronous active-high reset sets empty to 1, full to 0, the used count to 0 and the data output to 0x00.
- R2: In registered mode the data output changes only on a clock edge that accepts a read request. On that edge it takes the oldest stored byte, so the byte becomes visible one cycle after the request was raised.
- R3: In registered mode the data output stays at 0x00 after reset until the first accepted read, even while the buffer holds data.
- R4: In show-ahead mode the data output equals the oldest stored byte whenever the buffer is not empty, and a read request makes the next byte visible after the edge. While the buffer is empty the output is 0x00.
- R5: Bytes leave in the order they were written, including after the storage index has wrapped around the end of the array many times.
- R6: The used count rises by one on an accepted write alone and falls by one on an accepted read alone. It is unchanged when a write and a read are both accepted on the same edge. It is the stored word count modulo DEPTH, so it reads 0 when full.
- R7: Full is 1 exactly when DEPTH words are stored. Empty is 1 exactly when none are stored. The two are never 1 together.
- R8: A write request while full is ignored: the count stays the same and no stored byte changes. A read requested on the same edge is still accepted.
- R9: A read request while empty is ignored: the count stays 0 and the data output does not change. A write requested on the same edge is still accepted.
- R10: Empty rises on the same edge that accepts the read of the last stored byte. In registered mode that byte is on the output in the same cycle in which empty is already 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Push wr_data on this edge |
| wr_data | input | DW (8) | Byte to store |
| rd_req | input | 1 | Pop the oldest byte on this edge |
| rd_data | output | DW (8) | Read data; timing set by RD_MODE |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| used | output | log2(DEPTH) (6) | Stored word count modulo DEPTH |

## Verification
One registered-mode instance and one show-ahead instance receive identical stimulus, and both are compared each cycle against a queue model. Writes followed by a single read separate the two latencies and expose the initial 0x00 in registered mode. Filling to the brim and then pushing more exercises overflow protection and the count wrap at full. Reads on an empty buffer, with and without a write on the same edge, exercise underflow. Long runs of simultaneous reads and writes, and a stream of several hundred bytes, show that the count holds steady and that order survives index wrap.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    RD_REGISTERED = 1'b0,
    RD_SHOW_AHEAD = 1'b1
  } rd_mode_e;

  localparam int unsigned FIFO_DW    = 8;
  localparam int unsigned FIFO_DEPTH = 64;
endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl #(
  parameter int unsigned DEPTH = fifo_pkg::FIFO_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   count
);
  localparam logic [AW:0] LAST = AW'(DEPTH - 1);

  // requests are qualified by the registered flags
  assign wr_en = wr_req && !full;
  assign rd_en = rd_req && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      rd_addr <= '0;
      count   <= '0;
      empty   <= 1'b1;
      full    <= 1'b0;
    end else begin
      if (wr_en) wr_addr <= wr_addr + 1'b1;
      if (rd_en) rd_addr <= rd_addr + 1'b1;
      unique case ({wr_en, rd_en})
        2'b10: begin
          count <= count + 1'b1;
          empty <= 1'b0;
          full  <= (count == LAST);
        end
        2'b01: begin
          count <= count - 1'b1;
          full  <= 1'b0;
          empty <= (count == 1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned DW    = fifo_pkg::FIFO_DW,
  parameter int unsigned DEPTH = fifo_pkg::FIFO_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] mem [DEPTH];

  // no reset on the array so it maps onto RAM resources
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/fifo_rd_stage.sv
module fifo_rd_stage #(
  parameter int unsigned DW            = fifo_pkg::FIFO_DW,
  parameter fifo_pkg::rd_mode_e RD_MODE = fifo_pkg::RD_REGISTERED
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          empty,
  input  logic [DW-1:0] head,
  output logic [DW-1:0] rd_data
);
  generate
    if (RD_MODE == fifo_pkg::RD_REGISTERED) begin : g_reg
      logic [DW-1:0] q;
      logic          unused_reg_inputs;
      assign unused_reg_inputs = empty;
      always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (rd_en) q <= head;
      end
      assign rd_data = q;
    end else begin : g_ahead
      logic unused_ahead_inputs;
      assign unused_ahead_inputs = ^{clk, rst, rd_en};
      assign rd_data = empty ? '0 : head;
    end
  endgenerate
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DW             = fifo_pkg::FIFO_DW,
  parameter int unsigned DEPTH          = fifo_pkg::FIFO_DEPTH,
  parameter fifo_pkg::rd_mode_e RD_MODE = fifo_pkg::RD_REGISTERED,
  localparam int unsigned AW            = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic [AW-1:0] used
);
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [AW:0]   count;
  logic [DW-1:0] head;

  fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
    .wr_en(wr_en), .rd_en(rd_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .empty(empty), .full(full), .count(count)
  );

  fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(head)
  );

  fifo_rd_stage #(.DW(DW), .RD_MODE(RD_MODE)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .empty(empty),
    .head(head), .rd_data(rd_data)
  );

  // the count wraps to zero at full; the full flag tells the two apart
  assign used = count[AW-1:0];
endmodule

// File: rtl/fifo_chk.sv
module fifo_chk #(
  parameter int unsigned DW             = fifo_pkg::FIFO_DW,
  parameter int unsigned DEPTH          = fifo_pkg::FIFO_DEPTH,
  parameter fifo_pkg::rd_mode_e RD_MODE = fifo_pkg::RD_REGISTERED,
  localparam int unsigned AW            = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_req,
  input logic          rd_req,
  input logic [DW-1:0] rd_data,
  input logic          empty,
  input logic          full,
  input logic [AW-1:0] used
);
  localparam bit IS_REG = (RD_MODE == fifo_pkg::RD_REGISTERED);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (empty && !full && used == '0 && rd_data == '0)); // R1
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (IS_REG && !rd_req) |=> $stable(rd_data)); // R2
  AST_AHEAD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!IS_REG && empty) |-> rd_data == '0); // R4
  AST_STEADY_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!empty && !full && wr_req && rd_req) |=> ($stable(used) && !empty && !full)); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R7
  AST_FULL_WRAPS: assert property (@(posedge clk) disable iff (rst)
    full |-> used == '0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && !rd_req) |=> (full && $stable(used))); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req && !wr_req) |=> (empty && $stable(rd_data) && used == '0)); // R9
endmodule

bind byte_fifo fifo_chk #(.DW(DW), .DEPTH(DEPTH), .RD_MODE(RD_MODE)) u_chk (
  .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req), .rd_data(rd_data),
  .empty(empty), .full(full), .used(used)
);

// File: tb/test_byte_fifo.sv
module test_byte_fifo;
  localparam int DW    = 8;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_req = 1'b0;
  logic [DW-1:0] n_data, s_data;
  logic          n_empty, n_full, s_empty, s_full;
  logic [AW-1:0] n_used, s_used;

  int compared = 0;
  int mismatched = 0;
  logic [DW-1:0] q [$];
  logic [DW-1:0] exp_n = '0;

  always #5 clk = ~clk;

  byte_fifo #(.DW(DW), .DEPTH(DEPTH), .RD_MODE(fifo_pkg::RD_REGISTERED)) i_byte_fifo (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(n_data), .empty(n_empty), .full(n_full), .used(n_used)
  );

  byte_fifo #(.DW(DW), .DEPTH(DEPTH), .RD_MODE(fifo_pkg::RD_SHOW_AHEAD)) i_byte_fifo_sa (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(s_data), .empty(s_empty), .full(s_full), .used(s_used)
  );

  task automatic check(string tag, string what, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    int n = q.size();
    check(tag, "reg empty", int'(n_empty), int'(n == 0));
    check(tag, "reg full",  int'(n_full),  int'(n == DEPTH));
    check(tag, "reg used",  int'(n_used),  n % DEPTH);
    check(tag, "reg data",  int'(n_data),  int'(exp_n));
    check(tag, "sa empty",  int'(s_empty), int'(n == 0));
    check(tag, "sa full",   int'(s_full),  int'(n == DEPTH));
    check(tag, "sa used",   int'(s_used),  n % DEPTH);
    check(tag, "sa data",   int'(s_data),  (n == 0) ? 0 : int'(q[0]));
  endtask

  // one clock edge with the given requests, then model update and compare
  task automatic step(bit w, logic [DW-1:0] d, bit r, string tag);
    bit rd_ok, wr_ok;
    @(negedge clk);
    wr_req = w; wr_data = d; rd_req = r;
    @(posedge clk);
    #1;
    rd_ok = r && (q.size() > 0);
    wr_ok = w && (q.size() < DEPTH);
    if (rd_ok) exp_n = q.pop_front();
    if (wr_ok) q.push_back(d);
    check_all(tag);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    q.delete(); exp_n = '0;
    check_all("R1");
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_first_read;
    step(1'b1, 8'hA1, 1'b0, "R3");
    step(1'b1, 8'hB2, 1'b0, "R3");
    step(1'b1, 8'hC3, 1'b0, "R3");
    step(1'b0, 8'h00, 1'b0, "R3");   // registered output still 0x00
    step(1'b0, 8'h00, 1'b1, "R2");   // A1 appears after the accepting edge
    step(1'b0, 8'h00, 1'b0, "R2");   // held without request
    step(1'b0, 8'h00, 1'b1, "R4");
    step(1'b0, 8'h00, 1'b1, "R10");  // last word popped: empty with C3 on output
  endtask

  task automatic t_underflow;
    step(1'b0, 8'h00, 1'b1, "R9");
    step(1'b0, 8'h00, 1'b1, "R9");
    step(1'b1, 8'h5E, 1'b1, "R9");   // read ignored, write kept
    step(1'b0, 8'h00, 1'b1, "R9");
    step(1'b0, 8'h00, 1'b1, "R9");
  endtask

  task automatic t_fill;
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h40 + i), 1'b0, "R7");
    step(1'b1, 8'hEE, 1'b0, "R8");
    step(1'b1, 8'hEF, 1'b0, "R8");
    step(1'b1, 8'hF0, 1'b1, "R8");   // write dropped, read accepted
    step(1'b1, 8'hF1, 1'b0, "R6");   // refills to full
    for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h00, 1'b1, "R8");
  endtask

  task automatic t_simul;
    for (int i = 0; i < 10; i++) step(1'b1, 8'(8'h10 + i), 1'b0, "R6");
    for (int i = 0; i < 20; i++) step(1'b1, 8'(8'h80 + i), 1'b1, "R6");
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 1'b1, "R6");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 300; i++) step(1'b1, 8'(i * 7 + 3), (i % 3) != 0, "R5");
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 8'h00, 1'b1, "R5");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_first_read();
    t_underflow();
    t_fill();
    t_simul();
    t_wrap();
    t_reset();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule